// File: doc/BRIEF.md
# Split-Transaction Bus Agent Controller

This block sits in each agent attached to a shared bus on which every transaction takes the same five bus cycles. Every agent's copy counts through the phases in lockstep: bid, resolve, address, decode and acknowledge. In the bid phase the agent raises a bus request for its pending local transaction. The shared arbiter's verdict arrives during the resolve phase. A winning agent drives the address lines, and for a write the write-data lines too, during the address phase. A bus-wide sync strobe realigns every copy to the bid phase.

Reads are split. The address phase carries a tag naming one of eight read resources, which the agent holds as outstanding. The reply comes back later on the data path with that same tag. The controller looks the tag up among its valid resources, frees the matching one and reports the read as complete. A reply whose tag matches nothing is flagged as an error and leaves the table as it was. While every resource is busy, a read does not bid. Writes carry no tag and keep flowing.

Top module: `split_bus_ctrl`

## Requirements
- R1: After reset, `phase_o` is 0 (bid), all eight read resources are free, and `arb_req_o`, `addr_oe_o`, `wdata_oe_o`, `req_ack_o`, `done_o` and `err_o` are all low.
- R2: `phase_o` advances by one every clock through the encodings 0 bid, 1 resolve, 2 address, 3 decode, 4 acknowledge, and wraps from 4 back to 0.
- R3: When `bus_sync_i` is high at a clock edge, `phase_o` is 0 after that edge, whatever phase it held.
- R4: `arb_req_o` is high only while `phase_o` is 0 and a local request is pending that is either a write or a read with at least one free resource.
- R5: If the agent bid and `arb_grant_i` is high during the resolve phase, then during the following address phase `addr_oe_o` and `req_ack_o` are high and `bus_addr_o` carries the request address. `wdata_oe_o` is also high when the request is a write. Without a grant, none of these is driven.
- R6: A granted read is given the lowest-numbered free resource. That number appears on `bus_tag_o` during the address phase, and the resource counts as outstanding from the next cycle.
- R7: With all eight resources outstanding, a pending read does not raise `arb_req_o`, while a pending write still bids and is carried out.
- R8: A reply (`rsp_valid_i` high) whose `rsp_tag_i` names an outstanding resource makes `done_o` high on the next cycle with `done_tag_o` equal to that tag, and it frees the resource for reuse.
- R9: A reply whose tag names no outstanding resource makes `err_o` high on the next cycle, keeps `done_o` low, and leaves the set of outstanding resources unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sync_i | input | 1 | Bus-wide phase realignment strobe |
| req_valid_i | input | 1 | Local transaction pending |
| req_read_i | input | 1 | Pending transaction is a read (1) or a write (0) |
| req_addr_i | input | ADDR_W | Address of the pending transaction |
| req_ack_o | output | 1 | Pending transaction is placed on the bus this cycle |
| arb_req_o | output | 1 | Bus request raised in the bid phase |
| arb_grant_i | input | 1 | Arbiter verdict, sampled in the resolve phase |
| phase_o | output | 3 | Current bus phase, 0 to 4 |
| addr_oe_o | output | 1 | Address-line drive enable |
| wdata_oe_o | output | 1 | Write-data drive enable |
| bus_read_o | output | 1 | Read/write indication on the address lines |
| bus_addr_o | output | ADDR_W | Address driven on the bus |
| bus_tag_o | output | TAG_W | Read resource tag driven with a read address |
| rsp_valid_i | input | 1 | Read reply present on the data path |
| rsp_tag_i | input | TAG_W | Tag carried by the reply |
| done_o | output | 1 | A read completed |
| done_tag_o | output | TAG_W | Tag of the completed read |
| err_o | output | 1 | Reply tag matched no outstanding read |

## Verification
The bench builds the block with its default parameters: eight resources, 3-bit tags, a 16-bit address and lowest-first allocation. With only eight resources, filling and draining the whole table is a short, complete sweep. That reaches the full-table stall, the write that gets past it, a reply to every one of the eight tags, and an unmatched reply in both the partly filled and the empty table. Expected tags come from a small model of free resources kept in the bench. Phase values come from counting clocks modulo five.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
   localparam int unsigned NUM_PHASES = 5;
   localparam int unsigned PH_W       = 3;

   typedef enum logic [PH_W-1:0] {
      PH_BID     = 3'd0,
      PH_RESOLVE = 3'd1,
      PH_ADDRESS = 3'd2,
      PH_DECODE  = 3'd3,
      PH_ACK     = 3'd4
   } phase_e;
endpackage

// File: rtl/sbc_phase_seq.sv
module sbc_phase_seq
   import sbc_pkg::*;
(
   input  logic   clk_i,
   input  logic   rst_ni,
   input  logic   sync_i,
   output phase_e phase_o
);
   phase_e ph_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q <= PH_BID;
      end else if (sync_i || ph_q == PH_ACK) begin
         ph_q <= PH_BID;
      end else begin
         ph_q <= phase_e'(ph_q + 3'd1);
      end
   end

   assign phase_o = ph_q;
endmodule

// File: rtl/sbc_tag_table.sv
module sbc_tag_table #(
   parameter int unsigned NUM_RES   = 8,
   parameter int unsigned TAG_W     = 3,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               alloc_i,
   input  logic               rsp_valid_i,
   input  logic [TAG_W-1:0]   rsp_tag_i,
   output logic [NUM_RES-1:0] valid_o,
   output logic               full_o,
   output logic [TAG_W-1:0]   alloc_tag_o,
   output logic               done_o,
   output logic [TAG_W-1:0]   done_tag_o,
   output logic               err_o
);
   logic [NUM_RES-1:0] valid_q;
   logic [NUM_RES-1:0] set_vec;
   logic [NUM_RES-1:0] clr_vec;
   logic               hit;

   if (LOW_FIRST) begin : g_low_first
      always_comb begin
         alloc_tag_o = '0;
         for (int i = NUM_RES - 1; i >= 0; i--) begin
            if (!valid_q[i]) alloc_tag_o = TAG_W'(i);
         end
      end
   end else begin : g_high_first
      always_comb begin
         alloc_tag_o = '0;
         for (int i = 0; i < NUM_RES; i++) begin
            if (!valid_q[i]) alloc_tag_o = TAG_W'(i);
         end
      end
   end

   always_comb begin
      hit = 1'b0;
      for (int i = 0; i < NUM_RES; i++) begin
         if (rsp_valid_i && valid_q[i] && rsp_tag_i == TAG_W'(i)) hit = 1'b1;
      end
   end

   for (genvar g = 0; g < NUM_RES; g++) begin : g_entry
      assign set_vec[g] = alloc_i && !full_o && alloc_tag_o == TAG_W'(g);
      assign clr_vec[g] = hit && rsp_tag_i == TAG_W'(g);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_q    <= '0;
         done_o     <= 1'b0;
         err_o      <= 1'b0;
         done_tag_o <= '0;
      end else begin
         valid_q    <= (valid_q & ~clr_vec) | set_vec;
         done_o     <= hit;
         err_o      <= rsp_valid_i && !hit;
         done_tag_o <= hit ? rsp_tag_i : '0;
      end
   end

   assign full_o  = &valid_q;
   assign valid_o = valid_q;
endmodule

// File: rtl/split_bus_ctrl.sv
module split_bus_ctrl
   import sbc_pkg::*;
#(
   parameter int unsigned NUM_RES   = 8,
   parameter int unsigned TAG_W     = $clog2(NUM_RES),
   parameter int unsigned ADDR_W    = 16,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_sync_i,
   input  logic              req_valid_i,
   input  logic              req_read_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   output logic              req_ack_o,
   output logic              arb_req_o,
   input  logic              arb_grant_i,
   output logic [PH_W-1:0]   phase_o,
   output logic              addr_oe_o,
   output logic              wdata_oe_o,
   output logic              bus_read_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [TAG_W-1:0]  bus_tag_o,
   input  logic              rsp_valid_i,
   input  logic [TAG_W-1:0]  rsp_tag_i,
   output logic              done_o,
   output logic [TAG_W-1:0]  done_tag_o,
   output logic              err_o
);
   if (NUM_RES < 2) begin : g_chk_res
      $error("NUM_RES must be at least 2");
   end
   if ((1 << TAG_W) < NUM_RES) begin : g_chk_tag
      $error("TAG_W too narrow for NUM_RES");
   end
   if (ADDR_W < 1) begin : g_chk_addr
      $error("ADDR_W must be positive");
   end

   phase_e             phase;
   logic               bid_q;
   logic               won_q;
   logic               res_full;
   logic [NUM_RES-1:0] res_valid;
   logic [TAG_W-1:0]   free_tag;
   logic               drive;

   sbc_phase_seq u_phase (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sync_i  (bus_sync_i),
      .phase_o (phase)
   );

   assign arb_req_o = phase == PH_BID && req_valid_i && !(req_read_i && res_full);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bid_q <= 1'b0;
         won_q <= 1'b0;
      end else begin
         bid_q <= arb_req_o;
         won_q <= phase == PH_RESOLVE && bid_q && arb_grant_i && !bus_sync_i;
      end
   end

   assign drive      = won_q && phase == PH_ADDRESS;
   assign addr_oe_o  = drive;
   assign req_ack_o  = drive;
   assign wdata_oe_o = drive && !req_read_i;
   assign bus_read_o = drive && req_read_i;
   assign bus_addr_o = drive ? req_addr_i : '0;
   assign bus_tag_o  = (drive && req_read_i) ? free_tag : '0;
   assign phase_o    = phase;

   sbc_tag_table #(
      .NUM_RES   (NUM_RES),
      .TAG_W     (TAG_W),
      .LOW_FIRST (LOW_FIRST)
   ) u_table (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (drive && req_read_i),
      .rsp_valid_i (rsp_valid_i),
      .rsp_tag_i   (rsp_tag_i),
      .valid_o     (res_valid),
      .full_o      (res_full),
      .alloc_tag_o (free_tag),
      .done_o      (done_o),
      .done_tag_o  (done_tag_o),
      .err_o       (err_o)
   );
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
   parameter int unsigned NUM_RES = 8,
   parameter int unsigned TAG_W   = 3
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               sync,
   input logic [2:0]         phase,
   input logic               arb_req,
   input logic               req_read,
   input logic               addr_oe,
   input logic               done,
   input logic               err,
   input logic [TAG_W-1:0]   done_tag,
   input logic [NUM_RES-1:0] valid_vec
);
   AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sync && phase != 3'd4 |=> phase == $past(phase) + 3'd1); // R2
   AST_PHASE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sync && phase == 3'd4 |=> phase == 3'd0); // R2
   AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      phase <= 3'd4); // R2
   AST_SYNC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync |=> phase == 3'd0); // R3
   AST_BID_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arb_req |-> phase == 3'd0); // R4
   AST_DRIVE_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      addr_oe |-> phase == 3'd2 && $past(phase) == 3'd1); // R5
   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arb_req && req_read |-> !(&valid_vec)); // R7
   AST_DONE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done |-> !valid_vec[done_tag]); // R8
   AST_DONE_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(done && err)); // R9
endmodule

bind split_bus_ctrl sbc_checker #(
   .NUM_RES (NUM_RES),
   .TAG_W   (TAG_W)
) u_sbc_checker (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .sync      (bus_sync_i),
   .phase     (phase_o),
   .arb_req   (arb_req_o),
   .req_read  (req_read_i),
   .addr_oe   (addr_oe_o),
   .done      (done_o),
   .err       (err_o),
   .done_tag  (done_tag_o),
   .valid_vec (res_valid)
);

// File: tb/test_split_bus_ctrl.sv
module test_split_bus_ctrl;
   localparam int NUM_RES = 8;
   localparam int TAG_W   = 3;
   localparam int ADDR_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sync = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_read = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              arb_grant = 1'b0;
   logic              rsp_valid = 1'b0;
   logic [TAG_W-1:0]  rsp_tag = '0;
   logic              req_ack, arb_req, addr_oe, wdata_oe, bus_read, done, err;
   logic [2:0]        phase;
   logic [ADDR_W-1:0] bus_addr;
   logic [TAG_W-1:0]  bus_tag, done_tag;

   int checks = 0;
   int errors = 0;
   bit model_valid [NUM_RES];

   always #4 clk = ~clk;

   split_bus_ctrl i_split_bus_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .bus_sync_i(bus_sync),
      .req_valid_i(req_valid), .req_read_i(req_read), .req_addr_i(req_addr),
      .req_ack_o(req_ack), .arb_req_o(arb_req), .arb_grant_i(arb_grant),
      .phase_o(phase), .addr_oe_o(addr_oe), .wdata_oe_o(wdata_oe),
      .bus_read_o(bus_read), .bus_addr_o(bus_addr), .bus_tag_o(bus_tag),
      .rsp_valid_i(rsp_valid), .rsp_tag_i(rsp_tag), .done_o(done),
      .done_tag_o(done_tag), .err_o(err)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int lowest_free();
      for (int i = 0; i < NUM_RES; i++) if (!model_valid[i]) return i;
      return -1;
   endfunction

   task automatic to_phase(input int p);
      @(negedge clk);
      while (int'(phase) != p) @(negedge clk);
   endtask

   task automatic txn(input bit rd, input logic [ADDR_W-1:0] a, input bit g,
                      input bit exp_bid, input string r);
      int  tag;
      bit  won;
      tag = lowest_free();
      to_phase(0);
      req_valid = 1'b1; req_read = rd; req_addr = a;
      #1;
      check(r, "arb_req", int'(arb_req), int'(exp_bid));
      @(negedge clk);
      arb_grant = g;
      @(negedge clk);
      arb_grant = 1'b0;
      #1;
      won = exp_bid && g;
      check(r, "addr_oe", int'(addr_oe), int'(won));
      check(r, "req_ack", int'(req_ack), int'(won));
      check(r, "wdata_oe", int'(wdata_oe), int'(won && !rd));
      if (won) begin
         check(r, "bus_addr", int'(bus_addr), int'(a));
         check(r, "bus_read", int'(bus_read), int'(rd));
         if (rd) begin
            check("R6", "bus_tag", int'(bus_tag), tag);
            model_valid[tag] = 1'b1;
         end
      end
      @(negedge clk);
      req_valid = 1'b0; req_read = 1'b0;
   endtask

   task automatic reply(input int t);
      bit hit;
      hit = model_valid[t];
      @(negedge clk);
      rsp_valid = 1'b1; rsp_tag = TAG_W'(t);
      @(negedge clk);
      rsp_valid = 1'b0;
      #1;
      if (hit) begin
         check("R8", "done", int'(done), 1);
         check("R8", "done_tag", int'(done_tag), t);
         check("R8", "err", int'(err), 0);
         model_valid[t] = 1'b0;
      end else begin
         check("R9", "err", int'(err), 1);
         check("R9", "done", int'(done), 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < NUM_RES; i++) model_valid[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1", "phase", int'(phase), 0);
      check("R1", "arb_req", int'(arb_req), 0);
      check("R1", "addr_oe", int'(addr_oe), 0);
      check("R1", "wdata_oe", int'(wdata_oe), 0);
      check("R1", "req_ack", int'(req_ack), 0);
      check("R1", "done", int'(done), 0);
      check("R1", "err", int'(err), 0);

      // R2 phase sequence over three full rounds
      for (int k = 1; k <= 15; k++) begin
         @(negedge clk); #1;
         check("R2", "phase", int'(phase), k % 5);
      end

      // R3 sync from every phase
      for (int p = 0; p < 5; p++) begin
         to_phase(p);
         bus_sync = 1'b1;
         @(negedge clk); #1;
         bus_sync = 1'b0;
         check("R3", "phase", int'(phase), 0);
         @(negedge clk); #1;
         check("R3", "phase after", int'(phase), 1);
      end

      // R4 no bid without request, and bid outside slot
      to_phase(1);
      req_valid = 1'b1; req_read = 1'b0; #1;
      check("R4", "arb_req off-slot", int'(arb_req), 0);
      req_valid = 1'b0;
      to_phase(0); #1;
      check("R4", "arb_req idle", int'(arb_req), 0);

      // R5 ungranted then granted write
      txn(1'b0, 16'h1234, 1'b0, 1'b1, "R5");
      txn(1'b0, 16'h1234, 1'b1, 1'b1, "R5");

      // R6 fill all eight resources
      for (int i = 0; i < NUM_RES; i++) txn(1'b1, ADDR_W'(16'h4000 + i), 1'b1, 1'b1, "R6");

      // R7 full table: reads stall, writes pass
      txn(1'b1, 16'h5555, 1'b1, 1'b0, "R7");
      txn(1'b0, 16'hA0A0, 1'b1, 1'b1, "R7");

      // R8 free a middle tag, R9 repeat is unmatched, reuse shows state intact
      reply(3);
      reply(3);
      txn(1'b1, 16'h7777, 1'b1, 1'b1, "R6");
      reply(5);
      reply(1);
      txn(1'b1, 16'h7778, 1'b1, 1'b1, "R6");

      // R8 drain every tag, then R9 on empty table
      for (int t = NUM_RES - 1; t >= 0; t--) reply(t);
      for (int t = 0; t < NUM_RES; t++) reply(t);
      txn(1'b1, 16'h0042, 1'b1, 1'b1, "R6");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule